// File: doc/BRIEF.md
# Vector Control Register Access Unit

This block holds the small set of control registers that a scalar core uses to manage an attached vector unit. The scalar side sends one command at a time over a valid/ready request channel. Each command carries an 8-bit register address, a write flag and 32 bits of write data. The block answers with a one-cycle response that carries read data and a fault flag. Every register has its own access rights. An access that breaks those rights returns a reserved-operand fault and changes no state.

Two kinds of read must wait before they complete. A read of the memory-activity check register waits until the vector side reports that all earlier memory traffic has finished. A read of the status register that follows a status write waits until the vector side confirms that the new state is visible. While a read waits, the request channel is closed. Arithmetic exception events, illegal-opcode events, busy and memory-fault levels come in as inputs. A translation-buffer flush goes out as a one-cycle pulse.

Top module: `vcr_access`

## Requirements
- R1: Only addresses 0x90 to 0x94 are implemented. A read or a write to any other address, including the reserved range 0x95 to 0x9F, returns a fault.
- R2: A write to the exception summary (0x91), a write to the memory-activity check (0x92), or a read of the flush register (0x93) returns a fault and changes no register.
- R3: A status write (0x90) with any bit set outside bits 0, 1 and 3 returns a fault and changes no status bit.
- R4: The exception summary (0x91) gets bit c set by an event with condition code c, for c in {0,1,2,3,5}. Code 4 sets no summary bit. The same event also sets bit 16+v, where v is the destination vector register (0 to 15). Bits 4 and 15:6 always read zero.
- R5: Exception events accumulate by OR until a status write with bit 1 set clears the summary to zero.
- R6: A write of zero to 0x93 raises `tlb_flush` for exactly the one cycle after acceptance. A nonzero write to 0x93 returns a fault and produces no pulse.
- R7: A read of 0x92 gives no response while `mem_idle` is low. Once `mem_idle` is high, the read returns data 0 with no fault.
- R8: A status read that follows an accepted status write gives no response until `vsync_ack` has been seen.
- R9: The state address (0x94) can be read and written. A write with any of bits 2:0 set returns a fault and leaves the stored value unchanged.
- R10: The status read value is laid out as follows. Bit 0 is the enable bit, which software writes. Bit 1 always reads 0. Bit 2 follows `mem_fault`. Bit 3 is set by `illop_evt` and cleared by writing 1 to it or by a write with bit 1 set. Bit 31 follows `vec_busy`. All other bits read 0.
- R11: `req_ready` is low while a read is stalled. Each accepted request gets exactly one one-cycle `rsp_valid`. A faulted response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command can be accepted |
| req_addr | input | 8 | Register address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_fault | output | 1 | Reserved-operand fault |
| exc_valid | input | 1 | Arithmetic exception event strobe |
| exc_code | input | 3 | Exception condition code |
| exc_vreg | input | 4 | Destination vector register of the event |
| illop_evt | input | 1 | Illegal vector opcode event |
| vec_busy | input | 1 | Vector unit busy level |
| mem_fault | input | 1 | Pending vector memory fault level |
| mem_idle | input | 1 | All earlier vector memory accesses finished |
| vsync_ack | input | 1 | Vector side has made status changes visible |
| tlb_flush | output | 1 | Translation buffer invalidate-all pulse |

## Verification
Register accesses are driven across legal, reserved, read-only and write-only addresses. This separates the address decode from the rights check, and a faulting access is followed by a read-back that shows nothing changed. Exception events use distinct codes and register numbers, including code 4 and register 15, which exposes a wrong bit mapping or a lost accumulation. Both stall paths are held open for several cycles before their release input is raised, so a response that comes too early, or never comes, is caught.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int NVREG  = 16;
  localparam int VREG_W = $clog2(NVREG);
  localparam int VREG_BASE = 16;

  localparam logic [AW-1:0] A_STAT = 8'h90;
  localparam logic [AW-1:0] A_AEXC = 8'h91;
  localparam logic [AW-1:0] A_MCHK = 8'h92;
  localparam logic [AW-1:0] A_TBIA = 8'h93;
  localparam logic [AW-1:0] A_SADR = 8'h94;

  localparam int ST_EN   = 0;
  localparam int ST_RST  = 1;
  localparam int ST_ILL  = 3;
  localparam logic [DW-1:0] ST_WMASK  = 32'h0000_000B;
  localparam logic [DW-1:0] SUM_MASK  = 32'h0000_002F;

  typedef enum logic [2:0] {
    SEL_STAT, SEL_AEXC, SEL_MCHK, SEL_TBIA, SEL_SADR, SEL_NONE
  } sel_e;

  typedef enum logic {FSM_IDLE, FSM_HOLD} fsm_e;
endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
  import vcr_pkg::*;
#(
  parameter int ALIGN = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output sel_e          sel,
  output logic          fault
);
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << ALIGN) - 1);

  always_comb begin
    sel   = SEL_NONE;
    fault = 1'b1;
    case (addr)
      A_STAT: begin sel = SEL_STAT; fault = wr && (|(wdata & ~ST_WMASK)); end
      A_AEXC: begin sel = SEL_AEXC; fault = wr; end
      A_MCHK: begin sel = SEL_MCHK; fault = wr; end
      A_TBIA: begin sel = SEL_TBIA; fault = !wr || (|wdata); end
      A_SADR: begin sel = SEL_SADR; fault = wr && (|(wdata & LOW_MASK)); end
      default: begin sel = SEL_NONE; fault = 1'b1; end
    endcase
  end
endmodule

// File: rtl/vcr_regs.sv
module vcr_regs
  import vcr_pkg::*;
#(
  parameter int ALIGN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              wr_sel,
  input  logic [DW-1:0]     wdata,
  input  logic              exc_valid,
  input  logic [2:0]        exc_code,
  input  logic [VREG_W-1:0] exc_vreg,
  input  logic              illop_evt,
  input  logic              vec_busy,
  input  logic              mem_fault,
  input  logic              vsync_ack,
  output logic [DW-1:0]     stat_rd,
  output logic [DW-1:0]     aexc_rd,
  output logic [DW-1:0]     sadr_rd,
  output logic              tlb_flush,
  output logic              sync_pend
);
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << ALIGN) - 1);

  logic          en_q, en_d, ill_q, ill_d, pend_q, pend_d, flush_q, flush_d;
  logic [DW-1:0] aexc_q, aexc_d, sadr_q, sadr_d, evt;
  logic          stat_wr, rst_hit, sadr_wr;

  always_comb begin
    stat_wr = wr_en && (wr_sel == SEL_STAT);
    sadr_wr = wr_en && (wr_sel == SEL_SADR);
    rst_hit = stat_wr && wdata[ST_RST];
    en_d    = stat_wr ? wdata[ST_EN] : en_q;
    if (illop_evt)                              ill_d = 1'b1;
    else if (rst_hit || (stat_wr && wdata[ST_ILL])) ill_d = 1'b0;
    else                                        ill_d = ill_q;
    if (stat_wr)        pend_d = 1'b1;
    else if (vsync_ack) pend_d = 1'b0;
    else                pend_d = pend_q;
    evt = '0;
    if (exc_valid)
      evt = ((DW'(1) << exc_code) & SUM_MASK) | (DW'(1) << (VREG_BASE + int'(exc_vreg)));
    aexc_d  = rst_hit ? '0 : (aexc_q | evt);
    sadr_d  = sadr_wr ? (wdata & ~LOW_MASK) : sadr_q;
    flush_d = wr_en && (wr_sel == SEL_TBIA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ill_q   <= 1'b0;
      pend_q  <= 1'b0;
      flush_q <= 1'b0;
      aexc_q  <= '0;
      sadr_q  <= '0;
    end else begin
      en_q    <= en_d;
      ill_q   <= ill_d;
      pend_q  <= pend_d;
      flush_q <= flush_d;
      aexc_q  <= aexc_d;
      sadr_q  <= sadr_d;
    end
  end

  assign stat_rd   = {vec_busy, 27'b0, ill_q, mem_fault, 1'b0, en_q};
  assign aexc_rd   = aexc_q;
  assign sadr_rd   = sadr_q;
  assign tlb_flush = flush_q;
  assign sync_pend = pend_q;
endmodule

// File: rtl/vcr_resp.sv
module vcr_resp
  import vcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  sel_e          dec_sel,
  input  logic          dec_fault,
  input  logic          sync_pend,
  input  logic          mem_idle,
  input  logic [DW-1:0] stat_rd,
  input  logic [DW-1:0] aexc_rd,
  input  logic [DW-1:0] sadr_rd,
  output logic          req_ready,
  output logic          accept,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [DW-1:0] rsp_rdata
);
  fsm_e          state_q, state_d;
  sel_e          held_q, held_d, mux_sel;
  logic          rv_q, rv_d, rf_q, rf_d, read_ok, must_hold, release_hold;
  logic [DW-1:0] rd_q, rd_d, mux_data;

  always_comb begin
    req_ready = (state_q == FSM_IDLE);
    accept    = req_valid && req_ready;
    read_ok   = accept && !req_write && !dec_fault;
    must_hold = read_ok && (((dec_sel == SEL_STAT) && sync_pend) ||
                            ((dec_sel == SEL_MCHK) && !mem_idle));
    release_hold = (state_q == FSM_HOLD) &&
                   ((held_q == SEL_STAT) ? !sync_pend : mem_idle);
    mux_sel = (state_q == FSM_HOLD) ? held_q : dec_sel;
    case (mux_sel)
      SEL_STAT: mux_data = stat_rd;
      SEL_AEXC: mux_data = aexc_rd;
      SEL_SADR: mux_data = sadr_rd;
      default:  mux_data = '0;
    endcase
    state_d = state_q;
    held_d  = held_q;
    rv_d    = 1'b0;
    rf_d    = 1'b0;
    rd_d    = '0;
    if (accept) begin
      if (must_hold) begin
        state_d = FSM_HOLD;
        held_d  = dec_sel;
      end else begin
        rv_d = 1'b1;
        rf_d = dec_fault;
        rd_d = read_ok ? mux_data : '0;
      end
    end else if (release_hold) begin
      state_d = FSM_IDLE;
      rv_d    = 1'b1;
      rd_d    = mux_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      held_q  <= SEL_NONE;
      rv_q    <= 1'b0;
      rf_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      held_q  <= held_d;
      rv_q    <= rv_d;
      rf_q    <= rf_d;
      rd_q    <= rd_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_fault = rf_q;
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/vcr_access.sv
module vcr_access
  import vcr_pkg::*;
#(
  parameter int SADR_ALIGN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_fault,
  input  logic              exc_valid,
  input  logic [2:0]        exc_code,
  input  logic [VREG_W-1:0] exc_vreg,
  input  logic              illop_evt,
  input  logic              vec_busy,
  input  logic              mem_fault,
  input  logic              mem_idle,
  input  logic              vsync_ack,
  output logic              tlb_flush
);
  sel_e          dec_sel;
  logic          dec_fault, accept, wr_en, sync_pend;
  logic [DW-1:0] stat_rd, aexc_rd, sadr_rd;

  assign wr_en = accept && req_write && !dec_fault;

  vcr_decode #(.ALIGN(SADR_ALIGN)) u_decode (
    .addr(req_addr), .wr(req_write), .wdata(req_wdata),
    .sel(dec_sel), .fault(dec_fault)
  );

  vcr_regs #(.ALIGN(SADR_ALIGN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(dec_sel), .wdata(req_wdata),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_vreg(exc_vreg),
    .illop_evt(illop_evt), .vec_busy(vec_busy), .mem_fault(mem_fault),
    .vsync_ack(vsync_ack), .stat_rd(stat_rd), .aexc_rd(aexc_rd),
    .sadr_rd(sadr_rd), .tlb_flush(tlb_flush), .sync_pend(sync_pend)
  );

  vcr_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .dec_sel(dec_sel), .dec_fault(dec_fault), .sync_pend(sync_pend),
    .mem_idle(mem_idle), .stat_rd(stat_rd), .aexc_rd(aexc_rd), .sadr_rd(sadr_rd),
    .req_ready(req_ready), .accept(accept), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/vcr_access_chk.sv
module vcr_access_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  req_addr,
  input logic        req_write,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_fault,
  input logic        mem_idle,
  input logic        tlb_flush
);
  // R1: unimplemented addresses fault on the following cycle
  a_r1_reserved_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_addr >= 8'h95) && (req_addr <= 8'h9F))
    |=> (rsp_valid && rsp_fault));

  // R6: a flush pulse only follows an accepted zero write to 0x93
  a_r6_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(req_valid && req_ready && req_write &&
                        (req_addr == 8'h93) && (req_wdata == 32'h0)));

  // R7: memory check read is held while memory is not idle
  a_r7_mchk_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (req_addr == 8'h92) && !mem_idle)
    |=> (!rsp_valid && !req_ready));

  // R8: status read right after a legal status write is held
  a_r8_stat_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (req_addr == 8'h90) &&
     $past(req_valid && req_ready && req_write && (req_addr == 8'h90) &&
           ((req_wdata & 32'hFFFF_FFF4) == 32'h0)))
    |=> !rsp_valid);

  // R11: faulted responses carry zero data
  a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_rdata == 32'h0));
endmodule

bind vcr_access vcr_access_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
  .mem_idle(mem_idle), .tlb_flush(tlb_flush)
);

// File: tb/vcr_access_bench.sv
module vcr_access_bench;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_valid, rsp_fault;
  logic        exc_valid;
  logic [2:0]  exc_code;
  logic [3:0]  exc_vreg;
  logic        illop_evt, vec_busy, mem_fault, mem_idle, vsync_ack, tlb_flush;

  int n_chk = 0, n_fail = 0, cyc = 0;

  vcr_access u_vcr_access (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected < 50000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(output logic [31:0] rd, output logic f);
    int guard = 0;
    while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
    rd = rsp_rdata; f = rsp_fault;
    if (!rsp_valid) begin
      n_chk++; n_fail++;
      $display("FAIL R11 response timeout: actual 0 expected 1");
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic w, input logic [31:0] d,
                      output logic [31:0] rd, output logic f);
    issue(a, w, d);
    collect(rd, f);
  endtask

  task automatic exc_pulse(input logic [2:0] c, input logic [3:0] v);
    @(negedge clk); exc_valid = 1'b1; exc_code = c; exc_vreg = v;
    @(negedge clk); exc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic f;
    chk("R11", "ready after reset", 32'(req_ready), 32'h1);
    chk("R11", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R6", "flush after reset", 32'(tlb_flush), 32'h0);
    xfer(8'h90, 1'b0, 0, rd, f);
    chk("R10", "status after reset", rd, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] rd; logic f;
    xfer(8'h90, 1'b1, 32'h1, rd, f);
    chk("R10", "enable write fault", 32'(f), 32'h0);
    xfer(8'h90, 1'b0, 0, rd, f);
    chk("R10", "enable readback", rd, 32'h1);
    vec_busy = 1'b1; mem_fault = 1'b1;
    @(negedge clk); illop_evt = 1'b1; @(negedge clk); illop_evt = 1'b0;
    xfer(8'h90, 1'b0, 0, rd, f);
    chk("R10", "busy, fault, illegal bits", rd, 32'h8000_000D);
    xfer(8'h90, 1'b1, 32'h9, rd, f);
    xfer(8'h90, 1'b0, 0, rd, f);
    chk("R10", "illegal bit write-one-clear", rd, 32'h8000_0005);
    xfer(8'h90, 1'b1, 32'h3, rd, f);
    xfer(8'h90, 1'b0, 0, rd, f);
    chk("R10", "reset bit reads zero", rd, 32'h8000_0005);
    vec_busy = 1'b0; mem_fault = 1'b0;
  endtask

  task automatic t_reserved();
    logic [31:0] rd; logic f;
    logic [7:0] addrs [5] = '{8'h95, 8'h99, 8'h9F, 8'h8F, 8'h00};
    foreach (addrs[i]) begin
      xfer(addrs[i], 1'b0, 0, rd, f);
      chk("R1", $sformatf("read %h fault", addrs[i]), 32'(f), 32'h1);
      chk("R11", "fault data zero", rd, 32'h0);
      xfer(addrs[i], 1'b1, 32'h0, rd, f);
      chk("R1", $sformatf("write %h fault", addrs[i]), 32'(f), 32'h1);
    end
  endtask

  task automatic t_rights();
    logic [31:0] rd; logic f;
    exc_pulse(3'd2, 4'd1);
    xfer(8'h91, 1'b1, 32'h0, rd, f);
    chk("R2", "write exception summary fault", 32'(f), 32'h1);
    xfer(8'h91, 1'b0, 0, rd, f);
    chk("R2", "summary unchanged by write", rd, 32'h0002_0004);
    xfer(8'h93, 1'b0, 0, rd, f);
    chk("R2", "read flush fault", 32'(f), 32'h1);
    xfer(8'h92, 1'b1, 32'h0, rd, f);
    chk("R2", "write memory check fault", 32'(f), 32'h1);
  endtask

  task automatic t_mbz();
    logic [31:0] rd; logic f;
    xfer(8'h90, 1'b1, 32'h1, rd, f);
    xfer(8'h90, 1'b1, 32'h10, rd, f);
    chk("R3", "status MBZ fault", 32'(f), 32'h1);
    xfer(8'h90, 1'b0, 0, rd, f);
    chk("R3", "status unchanged", rd, 32'h1);
    xfer(8'h90, 1'b1, 32'h8000_0000, rd, f);
    chk("R3", "status read-only bit write fault", 32'(f), 32'h1);
  endtask

  task automatic t_sadr();
    logic [31:0] rd; logic f;
    xfer(8'h94, 1'b1, 32'hDEAD_BEE8, rd, f);
    chk("R9", "aligned write fault", 32'(f), 32'h0);
    xfer(8'h94, 1'b0, 0, rd, f);
    chk("R9", "address readback", rd, 32'hDEAD_BEE8);
    xfer(8'h94, 1'b1, 32'h1234_5679, rd, f);
    chk("R9", "unaligned write fault", 32'(f), 32'h1);
    xfer(8'h94, 1'b0, 0, rd, f);
    chk("R9", "address unchanged", rd, 32'hDEAD_BEE8);
  endtask

  task automatic t_exc();
    logic [31:0] rd; logic f;
    xfer(8'h90, 1'b1, 32'h3, rd, f);
    xfer(8'h91, 1'b0, 0, rd, f);
    chk("R5", "cleared by status reset bit", rd, 32'h0);
    exc_pulse(3'd0, 4'd0);
    exc_pulse(3'd5, 4'd15);
    exc_pulse(3'd4, 4'd7);
    xfer(8'h91, 1'b0, 0, rd, f);
    chk("R4", "summary and register bits", rd, 32'h8081_0021);
    exc_pulse(3'd1, 4'd3);
    exc_pulse(3'd3, 4'd3);
    xfer(8'h91, 1'b0, 0, rd, f);
    chk("R5", "accumulated bits", rd, 32'h8089_002B);
    xfer(8'h90, 1'b1, 32'h3, rd, f);
    xfer(8'h91, 1'b0, 0, rd, f);
    chk("R5", "clear after accumulate", rd, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] rd; logic f;
    issue(8'h93, 1'b1, 32'h0);
    chk("R6", "pulse after accept", 32'(tlb_flush), 32'h1);
    collect(rd, f);
    chk("R6", "zero write no fault", 32'(f), 32'h0);
    @(negedge clk);
    chk("R6", "pulse one cycle", 32'(tlb_flush), 32'h0);
    issue(8'h93, 1'b1, 32'h4);
    chk("R6", "no pulse on nonzero", 32'(tlb_flush), 32'h0);
    collect(rd, f);
    chk("R6", "nonzero write fault", 32'(f), 32'h1);
  endtask

  task automatic t_mchk();
    logic [31:0] rd; logic f; int early = 0; int rdy = 0;
    mem_idle = 1'b0;
    issue(8'h92, 1'b0, 0);
    for (int i = 0; i < 6; i++) begin
      early += int'(rsp_valid); rdy += int'(req_ready);
      @(negedge clk);
    end
    chk("R7", "no response while busy", 32'(early), 32'h0);
    chk("R11", "ready low while stalled", 32'(rdy), 32'h0);
    mem_idle = 1'b1;
    collect(rd, f);
    chk("R7", "memory check data", rd, 32'h0);
    chk("R7", "memory check fault", 32'(f), 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] rd; logic f; int early = 0;
    vsync_ack = 1'b0;
    xfer(8'h90, 1'b1, 32'h1, rd, f);
    issue(8'h90, 1'b0, 0);
    for (int i = 0; i < 6; i++) begin
      early += int'(rsp_valid);
      @(negedge clk);
    end
    chk("R8", "no response before ack", 32'(early), 32'h0);
    vsync_ack = 1'b1;
    collect(rd, f);
    chk("R8", "status after ack", rd, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
    exc_valid = 1'b0; exc_code = '0; exc_vreg = '0; illop_evt = 1'b0;
    vec_busy = 1'b0; mem_fault = 1'b0; mem_idle = 1'b1; vsync_ack = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_reserved();
    t_rights();
    t_mbz();
    t_sadr();
    t_exc();
    t_flush();
    t_mchk();
    t_sync();
    repeat (3) @(negedge clk);
    report();
  end
endmodule